// File: doc/BRIEF.md
# Copy-free checkpointed register rename table

This block maps architectural registers to physical register tags for a single-issue out-of-order core. Each accepted rename request looks up two source registers and may record one new destination mapping. Speculation is handled with epochs. An epoch is one table in a small ring of tables. A row of dirty flags per architectural register shows which live epoch tables hold a mapping for it. A separate committed table holds the architectural state.

Opening an epoch, retiring the oldest epoch and recovering to an earlier epoch only move two ring pointers and clear one flag column. No table contents are ever copied. Lookups are pipelined over two cycles. The first cycle searches the flag row for the newest live epoch that holds the register. The second cycle reads the flattened epoch memory and the committed memory, then picks one of the two.

The core must open an epoch before its first speculative rename. It should open a new epoch on the first instruction after each branch. It raises the retire flag on the commit of the last instruction of the oldest epoch. On a misprediction it recovers to the epoch that holds the branch.

Top module: `cfc_rename_table`

## Requirements
- R1: After reset, every architectural register i maps to physical tag i in the committed table, and `res_valid` is low.
- R2: A rename request is stalled (`ren_stall` high, no effect on any mapping, no result) in three cases: `rcv_valid` is high in the same cycle; it does not open an epoch while no epoch is live; or it opens an epoch while all 4 epochs are live.
- R3: An accepted request with `ren_open_epoch` high opens a new epoch whose id is the previous newest id plus one, modulo 4. The first epoch after reset is 0. A reused epoch table starts empty, so mappings left from its previous use are never returned.
- R4: An accepted request with `ren_dst_en` high records `ren_new_tag` for `ren_dst` in the newest epoch. A lookup accepted in the next cycle or later returns that tag.
- R5: A source lookup returns the mapping from the newest live epoch that holds the register. It skips newer epochs that do not hold it.
- R6: When no live epoch holds the register, the lookup returns the committed table entry. A commit write is seen by lookups accepted in the same cycle or later.
- R7: A commit with `cmt_retire` high frees the oldest live epoch. Lookups accepted after that cycle no longer consult it.
- R8: Recovery to epoch id e makes e the newest live epoch. Mappings recorded in epochs opened after e become invisible, and the next opened epoch is e+1 modulo 4.
- R9: The result for an accepted request appears on `res_valid`, `res_tag_a`, `res_tag_b` and `res_epoch` exactly one cycle after acceptance. `res_valid` is low in all other cycles.
- R10: Both sources of a request are looked up before its own destination is recorded. A request whose source equals its destination gets the older mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_open_epoch | input | 1 | Open a new epoch for this request |
| ren_src_a | input | 5 | First source architectural register |
| ren_src_b | input | 5 | Second source architectural register |
| ren_dst_en | input | 1 | Request writes a destination |
| ren_dst | input | 5 | Destination architectural register |
| ren_new_tag | input | 6 | Physical tag for the destination |
| ren_stall | output | 1 | Request not accepted this cycle |
| res_valid | output | 1 | Lookup result valid |
| res_tag_a | output | 6 | Physical tag of first source |
| res_tag_b | output | 6 | Physical tag of second source |
| res_epoch | output | 2 | Epoch holding the renamed instruction |
| cmt_valid | input | 1 | Commit write present |
| cmt_arch | input | 5 | Committed architectural register |
| cmt_tag | input | 6 | Committed physical tag |
| cmt_retire | input | 1 | Free the oldest live epoch |
| rcv_valid | input | 1 | Recover after misprediction |
| rcv_epoch | input | 2 | Epoch to recover to |

## Verification
The assertions check, on every cycle, that the live epoch count never exceeds four. They also check that the ring pointers stay linked when no epoch is live, that a stalled cycle leaves the newest epoch unchanged, and that recovery lands on the requested epoch. They further check that a freshly opened column holds at most the one flag just set, that flag sets and committed writes land where addressed, and that results follow acceptances by exactly one cycle. Only the bench scenarios can show which tag a lookup returns. That covers the search order across epochs, stale data in a reused table staying hidden, same-cycle commit visibility, and the sources of an instruction being read ahead of its own destination. The bench shows these by comparing every result against an independent model of epochs kept as a queue.

// File: rtl/cfc_rat_pkg.sv
package cfc_rat_pkg;
  localparam int DEF_ARCH_REGS = 32;
  localparam int DEF_PHYS_REGS = 64;
  localparam int DEF_EPOCHS    = 4;

  // Which memory answers a source lookup in stage 2
  typedef enum logic {
    SRC_EPOCH  = 1'b0,
    SRC_COMMIT = 1'b1
  } src_sel_e;
endpackage

// File: rtl/cfc_newest_find.sv
// Priority search over one dirty row: newest live epoch first.
module cfc_newest_find #(
  parameter int NUM_EPOCHS = 4,
  parameter int CW = $clog2(NUM_EPOCHS),
  parameter int LW = $clog2(NUM_EPOCHS + 1)
) (
  input  logic [NUM_EPOCHS-1:0] row,
  input  logic [CW-1:0]         head,
  input  logic [LW-1:0]         live,
  output logic                  hit,
  output logic [CW-1:0]         epoch
);
  logic [CW-1:0] probe;

  // Walk from the oldest live position to the newest so the newest hit wins.
  always_comb begin
    hit   = 1'b0;
    epoch = head;
    probe = head;
    for (int k = NUM_EPOCHS - 1; k >= 0; k--) begin
      probe = head - CW'(k);
      if ((LW'(k) < live) && row[probe]) begin
        hit   = 1'b1;
        epoch = probe;
      end
    end
  end
endmodule

// File: rtl/cfc_dirty_grid.sv
// Dirty flags: one row per architectural register, one column per epoch.
module cfc_dirty_grid #(
  parameter int NUM_ARCH   = 32,
  parameter int NUM_EPOCHS = 4,
  parameter int NRD        = 2,
  parameter int AW = $clog2(NUM_ARCH),
  parameter int CW = $clog2(NUM_EPOCHS),
  parameter int LW = $clog2(NUM_EPOCHS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_en,
  input  logic [CW-1:0]           clr_col,
  input  logic                    set_en,
  input  logic [AW-1:0]           set_row,
  input  logic [CW-1:0]           set_col,
  input  logic [CW-1:0]           head,
  input  logic [LW-1:0]           live,
  input  logic [NRD-1:0][AW-1:0]  look_arch,
  output logic [NRD-1:0]          look_hit,
  output logic [NRD-1:0][CW-1:0]  look_epoch
);
  logic [NUM_EPOCHS-1:0] dirty_q [NUM_ARCH];
  logic [NUM_EPOCHS-1:0] dirty_d [NUM_ARCH];
  logic                  grid_en;
  logic [NUM_ARCH-1:0]   head_col;

  assign grid_en = clr_en | set_en;

  always_comb begin
    for (int r = 0; r < NUM_ARCH; r++) begin
      dirty_d[r] = dirty_q[r];
      if (clr_en) dirty_d[r][clr_col] = 1'b0;
    end
    if (set_en) dirty_d[set_row][set_col] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ARCH; r++) dirty_q[r] <= '0;
    end else if (grid_en) begin
      for (int r = 0; r < NUM_ARCH; r++) dirty_q[r] <= dirty_d[r];
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_find
    cfc_newest_find #(
      .NUM_EPOCHS(NUM_EPOCHS), .CW(CW), .LW(LW)
    ) u_find (
      .row   (dirty_q[look_arch[g]]),
      .head  (head),
      .live  (live),
      .hit   (look_hit[g]),
      .epoch (look_epoch[g])
    );
  end

  always_comb begin
    for (int r = 0; r < NUM_ARCH; r++) head_col[r] = dirty_q[r][head];
  end

  AST_FLAG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> dirty_q[$past(set_row)][$past(set_col)]); // R4
  AST_FRESH_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ($countones(head_col) <= 1)); // R3
endmodule

// File: rtl/cfc_map_store.sv
// Flattened epoch memory plus a separate committed memory.
module cfc_map_store #(
  parameter int NUM_ARCH   = 32,
  parameter int NUM_PHYS   = 64,
  parameter int NUM_EPOCHS = 4,
  parameter int NRD        = 2,
  parameter int AW = $clog2(NUM_ARCH),
  parameter int PW = $clog2(NUM_PHYS),
  parameter int CW = $clog2(NUM_EPOCHS),
  parameter int IW = CW + AW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ep_we,
  input  logic [IW-1:0]          ep_waddr,
  input  logic [PW-1:0]          ep_wdata,
  input  logic                   cm_we,
  input  logic [AW-1:0]          cm_waddr,
  input  logic [PW-1:0]          cm_wdata,
  input  logic [NRD-1:0][IW-1:0] rd_ep_addr,
  input  logic [NRD-1:0][AW-1:0] rd_cm_addr,
  input  logic [NRD-1:0]         rd_use_cm,
  output logic [NRD-1:0][PW-1:0] rd_tag
);
  localparam int DEPTH = NUM_EPOCHS * NUM_ARCH;

  logic [PW-1:0] ep_mem [DEPTH];
  logic [PW-1:0] cm_mem [NUM_ARCH];

  // Epoch tables need no reset: dirty flags gate every read.
  always_ff @(posedge clk) begin
    if (ep_we) ep_mem[ep_waddr] <= ep_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) cm_mem[i] <= PW'(i);
    end else if (cm_we) begin
      cm_mem[cm_waddr] <= cm_wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_tag[g] = rd_use_cm[g] ? cm_mem[rd_cm_addr[g]] : ep_mem[rd_ep_addr[g]];
  end

  AST_COMMIT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    cm_we |=> (cm_mem[$past(cm_waddr)] == $past(cm_wdata))); // R6
endmodule

// File: rtl/cfc_epoch_ctrl.sv
// Ring pointers, live count, stall and recovery.
module cfc_epoch_ctrl #(
  parameter int NUM_EPOCHS = 4,
  parameter int CW = $clog2(NUM_EPOCHS),
  parameter int LW = $clog2(NUM_EPOCHS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_req,
  input  logic          open_req,
  input  logic          retire_req,
  input  logic          rcv_req,
  input  logic [CW-1:0] rcv_epoch,
  output logic          stall,
  output logic          accept,
  output logic          alloc_fire,
  output logic [CW-1:0] tgt_epoch,
  output logic [CW-1:0] head,
  output logic [LW-1:0] live
);
  logic [CW-1:0] head_q, head_d, tail_q, tail_d, span;
  logic [LW-1:0] live_q, live_d;
  logic          full, empty, retire_fire, rcv_fire, ptr_en;

  assign full        = (live_q == LW'(NUM_EPOCHS));
  assign empty       = (live_q == '0);
  assign stall       = ren_req & (rcv_req | (open_req ? full : empty));
  assign accept      = ren_req & ~stall;
  assign alloc_fire  = accept & open_req;
  assign retire_fire = retire_req & ~empty;
  assign rcv_fire    = rcv_req & ~empty;
  assign tgt_epoch   = open_req ? head_q + CW'(1) : head_q;
  assign ptr_en      = alloc_fire | retire_fire | rcv_fire;

  always_comb begin
    tail_d = retire_fire ? tail_q + CW'(1) : tail_q;
    span   = rcv_epoch - tail_d;
    if (rcv_fire) begin
      head_d = rcv_epoch;
      live_d = LW'(span) + LW'(1);
    end else begin
      head_d = alloc_fire ? head_q + CW'(1) : head_q;
      live_d = live_q + LW'(alloc_fire) - LW'(retire_fire);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= CW'(NUM_EPOCHS - 1);
      tail_q <= '0;
      live_q <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      live_q <= live_d;
    end
  end

  assign head = head_q;
  assign live = live_q;

  AST_LIVE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    live_q <= LW'(NUM_EPOCHS)); // R2
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rcv_req) |=> $stable(head_q)); // R2
  AST_EMPTY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q == '0) |-> (head_q + CW'(1) == tail_q)); // R7
  AST_RECOVER_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_fire |=> (head_q == $past(rcv_epoch))); // R8
endmodule

// File: rtl/cfc_rename_table.sv
module cfc_rename_table
  import cfc_rat_pkg::*;
#(
  parameter int NUM_ARCH   = DEF_ARCH_REGS,
  parameter int NUM_PHYS   = DEF_PHYS_REGS,
  parameter int NUM_EPOCHS = DEF_EPOCHS,
  parameter int AW = $clog2(NUM_ARCH),
  parameter int PW = $clog2(NUM_PHYS),
  parameter int CW = $clog2(NUM_EPOCHS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic          ren_open_epoch,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic          ren_dst_en,
  input  logic [AW-1:0] ren_dst,
  input  logic [PW-1:0] ren_new_tag,
  output logic          ren_stall,
  output logic          res_valid,
  output logic [PW-1:0] res_tag_a,
  output logic [PW-1:0] res_tag_b,
  output logic [CW-1:0] res_epoch,
  input  logic          cmt_valid,
  input  logic [AW-1:0] cmt_arch,
  input  logic [PW-1:0] cmt_tag,
  input  logic          cmt_retire,
  input  logic          rcv_valid,
  input  logic [CW-1:0] rcv_epoch
);
  localparam int NRD = 2;
  localparam int LW  = $clog2(NUM_EPOCHS + 1);
  localparam int IW  = CW + AW;

  logic                  accept, alloc_fire;
  logic [CW-1:0]         tgt_epoch, head;
  logic [LW-1:0]         live;
  logic [NRD-1:0][AW-1:0] look_arch;
  logic [NRD-1:0]        look_hit;
  logic [NRD-1:0][CW-1:0] look_epoch;

  // stage-2 registers
  logic                  s2_valid_q, s2_valid_d;
  logic [NRD-1:0][IW-1:0] s2_ep_addr_q, s2_ep_addr_d;
  logic [NRD-1:0][AW-1:0] s2_cm_addr_q, s2_cm_addr_d;
  logic [NRD-1:0]        s2_use_cm_q, s2_use_cm_d;
  logic [CW-1:0]         s2_epoch_q, s2_epoch_d;
  logic                  s2_wr_q, s2_wr_d;
  logic [IW-1:0]         s2_waddr_q, s2_waddr_d;
  logic [PW-1:0]         s2_wtag_q, s2_wtag_d;
  logic [NRD-1:0][PW-1:0] rd_tag;

  cfc_epoch_ctrl #(.NUM_EPOCHS(NUM_EPOCHS), .CW(CW), .LW(LW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ren_req    (ren_valid),
    .open_req   (ren_open_epoch),
    .retire_req (cmt_valid & cmt_retire),
    .rcv_req    (rcv_valid),
    .rcv_epoch  (rcv_epoch),
    .stall      (ren_stall),
    .accept     (accept),
    .alloc_fire (alloc_fire),
    .tgt_epoch  (tgt_epoch),
    .head       (head),
    .live       (live)
  );

  assign look_arch[0] = ren_src_a;
  assign look_arch[1] = ren_src_b;

  // Stage 1: flag search, index forming, flag update
  cfc_dirty_grid #(
    .NUM_ARCH(NUM_ARCH), .NUM_EPOCHS(NUM_EPOCHS), .NRD(NRD),
    .AW(AW), .CW(CW), .LW(LW)
  ) u_grid (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_en     (alloc_fire),
    .clr_col    (tgt_epoch),
    .set_en     (accept & ren_dst_en),
    .set_row    (ren_dst),
    .set_col    (tgt_epoch),
    .head       (head),
    .live       (live),
    .look_arch  (look_arch),
    .look_hit   (look_hit),
    .look_epoch (look_epoch)
  );

  always_comb begin
    s2_valid_d = accept;
    for (int g = 0; g < NRD; g++) begin
      s2_ep_addr_d[g] = {look_epoch[g], look_arch[g]};
      s2_cm_addr_d[g] = look_arch[g];
      s2_use_cm_d[g]  = look_hit[g] ? SRC_EPOCH : SRC_COMMIT;
    end
    s2_epoch_d = tgt_epoch;
    s2_wr_d    = accept & ren_dst_en;
    s2_waddr_d = {tgt_epoch, ren_dst};
    s2_wtag_d  = ren_new_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid_q <= 1'b0;
      s2_wr_q    <= 1'b0;
    end else begin
      s2_valid_q <= s2_valid_d;
      s2_wr_q    <= s2_wr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s2_ep_addr_q <= s2_ep_addr_d;
      s2_cm_addr_q <= s2_cm_addr_d;
      s2_use_cm_q  <= s2_use_cm_d;
      s2_epoch_q   <= s2_epoch_d;
      s2_waddr_q   <= s2_waddr_d;
      s2_wtag_q    <= s2_wtag_d;
    end
  end

  // Stage 2: parallel read, select, writes at end of cycle
  cfc_map_store #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_EPOCHS(NUM_EPOCHS),
    .NRD(NRD), .AW(AW), .PW(PW), .CW(CW), .IW(IW)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .ep_we      (s2_wr_q),
    .ep_waddr   (s2_waddr_q),
    .ep_wdata   (s2_wtag_q),
    .cm_we      (cmt_valid),
    .cm_waddr   (cmt_arch),
    .cm_wdata   (cmt_tag),
    .rd_ep_addr (s2_ep_addr_q),
    .rd_cm_addr (s2_cm_addr_q),
    .rd_use_cm  (s2_use_cm_q),
    .rd_tag     (rd_tag)
  );

  assign res_valid = s2_valid_q;
  assign res_tag_a = rd_tag[0];
  assign res_tag_b = rd_tag[1];
  assign res_epoch = s2_epoch_q;

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid); // R9
  AST_NO_GHOST: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !res_valid); // R9
endmodule

// File: tb/tb_cfc_rename_table.sv
module tb_cfc_rename_table;
  localparam int NA = 32;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ren_valid, ren_open_epoch, ren_dst_en, ren_stall, res_valid;
  logic [4:0] ren_src_a, ren_src_b, ren_dst, cmt_arch;
  logic [5:0] ren_new_tag, res_tag_a, res_tag_b, cmt_tag;
  logic [1:0] res_epoch, rcv_epoch;
  logic cmt_valid, cmt_retire, rcv_valid;

  always #2 clk = ~clk;

  cfc_rename_table dut (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_open_epoch(ren_open_epoch),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
    .ren_dst_en(ren_dst_en), .ren_dst(ren_dst), .ren_new_tag(ren_new_tag),
    .ren_stall(ren_stall), .res_valid(res_valid),
    .res_tag_a(res_tag_a), .res_tag_b(res_tag_b), .res_epoch(res_epoch),
    .cmt_valid(cmt_valid), .cmt_arch(cmt_arch), .cmt_tag(cmt_tag),
    .cmt_retire(cmt_retire), .rcv_valid(rcv_valid), .rcv_epoch(rcv_epoch)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural model
  int cmt_map [NA];
  int ep_tag [NE][NA];
  bit ep_has [NE][NA];
  int live_q [$];
  int newest = NE - 1;

  bit    p_v = 0;
  int    p_a, p_b, p_e;
  string p_req;

  task automatic chk(bit ok, string req, string what, int got, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  function automatic int look(int r);
    for (int i = live_q.size() - 1; i >= 0; i--)
      if (ep_has[live_q[i]][r]) return ep_tag[live_q[i]][r];
    return cmt_map[r];
  endfunction

  task automatic step(string req, bit rv, bit op, int sa, int sb, bit de, int d, int t,
                      bit cv, int ca, int ct, bit cr, bit xv, int xe);
    bit st;
    int ea, eb;
    @(negedge clk);
    chk(res_valid === p_v, "R9", "res_valid", int'(res_valid), int'(p_v));
    if (p_v) begin
      chk(res_tag_a == 6'(p_a), p_req, "tag_a", int'(res_tag_a), p_a);
      chk(res_tag_b == 6'(p_b), p_req, "tag_b", int'(res_tag_b), p_b);
      chk(res_epoch == 2'(p_e), p_req, "epoch", int'(res_epoch), p_e);
    end
    ren_valid = rv; ren_open_epoch = op;
    ren_src_a = 5'(sa); ren_src_b = 5'(sb);
    ren_dst_en = de; ren_dst = 5'(d); ren_new_tag = 6'(t);
    cmt_valid = cv; cmt_arch = 5'(ca); cmt_tag = 6'(ct); cmt_retire = cr;
    rcv_valid = xv; rcv_epoch = 2'(xe);
    #1;
    st = rv && (xv || (op ? (live_q.size() == NE) : (live_q.size() == 0)));
    chk(ren_stall === st, "R2", "stall", int'(ren_stall), int'(st));
    if (cv) cmt_map[ca] = ct;
    p_v = rv && !st;
    if (p_v) begin
      ea = look(sa);
      eb = look(sb);
      if (op) begin
        newest = (newest + 1) % NE;
        for (int r = 0; r < NA; r++) ep_has[newest][r] = 0;
        live_q.push_back(newest);
      end
      if (de) begin
        ep_has[newest][d] = 1;
        ep_tag[newest][d] = t;
      end
      p_a = ea; p_b = eb; p_e = newest; p_req = req;
    end
    if (cv && cr && live_q.size() > 0) void'(live_q.pop_front());
    if (xv && live_q.size() > 0) begin
      while (live_q.size() > 1 && live_q[live_q.size() - 1] != xe) void'(live_q.pop_back());
      newest = xe;
    end
  endtask

  task automatic idle();
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog got=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NA; i++) cmt_map[i] = i;
    rst_n = 1'b0;
    ren_valid = 0; ren_open_epoch = 0; ren_src_a = 0; ren_src_b = 0;
    ren_dst_en = 0; ren_dst = 0; ren_new_tag = 0;
    cmt_valid = 0; cmt_arch = 0; cmt_tag = 0; cmt_retire = 0;
    rcv_valid = 0; rcv_epoch = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(res_valid === 1'b0, "R1", "reset res_valid", int'(res_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // no epoch live: plain rename stalls
    step("R2", 1, 0, 1, 2, 1, 5, 33, 0, 0, 0, 0, 0, 0);
    // first epoch 0; identity map; source equal to destination reads old
    step("R1", 1, 1, 3, 7, 1, 3, 40, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 0, 3, 3, 1, 3, 41, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 0, 3, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // epoch 1
    step("R3", 1, 1, 3, 9, 1, 9, 50, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 9, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // epochs 2 and 3, then full
    step("R3", 1, 1, 3, 5, 1, 3, 42, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 3, 9, 1, 5, 43, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 1, 3, 5, 1, 3, 63, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 3, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // recover to epoch 1 (rename in that cycle stalls)
    step("R8", 1, 0, 3, 5, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R8", 1, 0, 3, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // reopen epoch 2: old contents hidden
    step("R3", 1, 1, 3, 5, 1, 5, 44, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 5, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // commits retire epochs 0,1,2
    step("R6", 1, 0, 9, 3, 0, 0, 0, 1, 3, 40, 1, 0, 0);
    step("R7", 1, 0, 3, 9, 0, 0, 0, 1, 9, 50, 1, 0, 0);
    step("R7", 1, 0, 5, 3, 0, 0, 0, 1, 5, 44, 1, 0, 0);
    step("R2", 1, 0, 3, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // same-cycle commit visible to a committed-table lookup
    step("R6", 1, 1, 12, 3, 0, 0, 0, 1, 12, 60, 0, 0, 0);
    step("R7", 1, 0, 9, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      bit rv, op, de, cv, cr, xv;
      int xe;
      rv = ($urandom % 4) != 0;
      op = ($urandom % 5) == 0;
      de = ($urandom % 4) != 0;
      cv = ($urandom % 3) == 0;
      cr = cv && (($urandom % 4) == 0);
      xv = !cr && (live_q.size() > 0) && (($urandom % 25) == 0);
      xe = (live_q.size() > 0) ? live_q[$urandom_range(live_q.size() - 1, 0)] : 0;
      step("R5", rv, op, $urandom % NA, $urandom % NA, de, $urandom % NA, $urandom % 64,
           cv, $urandom % NA, $urandom % 64, cr, xv, xe);
    end
    idle();
    idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule